// File: doc/BRIEF.md
# Four-Bit Eight-Function ALU

A purely combinational arithmetic logic unit. Two operands `a` and `b` and a 3-bit function code `sel` produce a result `r` and two flags: `carry`, which is meaningful when the operands are read as unsigned numbers, and `ovf`, which is meaningful when they are read as two's-complement numbers. Operands may also be treated as plain bit patterns, and the three bitwise functions do exactly that.

The block has no clock, no state and no handshake. It is meant to sit inside a datapath where the surrounding logic registers the inputs and outputs as it needs. All five arithmetic functions share one adder. Each function picks that adder's two inputs and its carry-in.

Top module: `alu4`

## Requirements
- R1: With `sel`=000, `r` is (a + b) mod 16 and `carry` is bit 4 of the 5-bit sum a + b.
- R2: With `sel`=001, `r` is (a - b) mod 16 and `carry` is 1 exactly when a >= b (unsigned), meaning no borrow.
- R3: With `sel`=010, `r` is (b + 1) mod 16. With `sel`=011, `r` is (b - 1) mod 16.
- R4: With `sel`=100, `r` is the two's-complement negation of `a`, that is (16 - a) mod 16.
- R5: With `sel`=101, `r` is ~a. With `sel`=110, `r` is a | b. With `sel`=111, `r` is a & b.
- R6: For `sel`=101, 110 and 111, `carry` and `ovf` are both 0.
- R7: With `sel`=000, `ovf` is 1 exactly when a[3] = b[3] and r[3] differs from them. This is the case when the signed sum falls outside -8..7.
- R8: With `sel`=001, `ovf` is 1 exactly when the signed difference a - b falls outside -8..7.
- R9: For increment, `carry` is 1 only for b=1111 and `ovf` is 1 only for b=0111. For decrement, `carry` is 0 only for b=0000 and `ovf` is 1 only for b=1000.
- R10: For negation, `carry` is 1 only for a=0000 and `ovf` is 1 only for a=1000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W (4) | First operand |
| b | input | W (4) | Second operand |
| sel | input | 3 | Function code, encoded as listed in R1 to R5 |
| r | output | W (4) | Result |
| carry | output | 1 | Carry out, or no-borrow for subtraction |
| ovf | output | 1 | Two's-complement overflow |

## Verification
The bench builds the block with its default width of four. At that width the inputs form only eleven bits, so every one of the 2048 combinations of `sel`, `a` and `b` is compared against an arithmetic model that works on signed and unsigned integers. Before the sweep, a table of sixteen hand-derived vectors runs every function on two operand pairs, (1111, 0010) and (1001, 0111). After the sweep, directed cases cover the single operand values where increment, decrement and negation set or clear their flags.

// File: rtl/alu4.sv
module alu4 #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   sel,
  output logic [W-1:0] r,
  output logic         carry,
  output logic         ovf
);
  localparam int M = W - 1;

  logic [W-1:0] x, y, lres;
  logic         cin, arith;
  logic [W:0]   sum;

  // one shared adder: each arithmetic code chooses its adder inputs
  always_comb begin
    x = a; y = b; cin = 1'b0;
    case (sel)
      3'd0:    begin x = a;  y = b;         cin = 1'b0; end
      3'd1:    begin x = a;  y = ~b;        cin = 1'b1; end
      3'd2:    begin x = b;  y = '0;        cin = 1'b1; end
      3'd3:    begin x = b;  y = '1;        cin = 1'b0; end
      3'd4:    begin x = ~a; y = '0;        cin = 1'b1; end
      default: begin x = '0; y = '0;        cin = 1'b0; end
    endcase
  end

  always_comb begin
    case (sel[1:0])
      2'b01:   lres = ~a;
      2'b10:   lres = a | b;
      2'b11:   lres = a & b;
      default: lres = '0;
    endcase
  end

  assign sum   = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  assign arith = ~sel[2] | (sel[1:0] == 2'b00);
  assign r     = arith ? sum[W-1:0] : lres;
  assign carry = arith & sum[W];
  assign ovf   = arith & (x[M] == y[M]) & (sum[M] != x[M]);

  always_comb begin
    if (sel == 3'd0)
      p_add_inverse_r1: assert ((r - b) == a) else $error("R1 add result");
    if (sel == 3'd1)
      p_sub_inverse_r2: assert ((r + b) == a) else $error("R2 sub result");
    if (sel == 3'd4)
      p_neg_cancels_r4: assert ((r + a) == '0) else $error("R4 negate result");
    if (sel >= 3'd5)
      p_no_flags_r6: assert (!carry && !ovf) else $error("R6 flags on bitwise op");
    if (sel == 3'd0 && ovf)
      p_add_ovf_sign_r7: assert (a[M] == b[M] && r[M] != a[M]) else $error("R7 add overflow");
    if (sel == 3'd4 && ovf)
      p_neg_ovf_min_r10: assert (a == {1'b1, {M{1'b0}}}) else $error("R10 negate overflow");
  end
endmodule

// File: tb/sim_alu4.sv
module sim_alu4;
  localparam int W = 4;
  localparam int N = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic [2:0] sel = '0;
  logic [W-1:0] r;
  logic carry, ovf;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  alu4 #(.W(W)) u0 (.a(a), .b(b), .sel(sel), .r(r), .carry(carry), .ovf(ovf));

  // {sel, a, b, r, carry, ovf}
  localparam logic [16:0] VEC [0:15] = '{
    {3'd0, 4'hF, 4'h2, 4'h1, 1'b1, 1'b0},
    {3'd1, 4'hF, 4'h2, 4'hD, 1'b1, 1'b0},
    {3'd2, 4'hF, 4'h2, 4'h3, 1'b0, 1'b0},
    {3'd3, 4'hF, 4'h2, 4'h1, 1'b1, 1'b0},
    {3'd4, 4'hF, 4'h2, 4'h1, 1'b0, 1'b0},
    {3'd5, 4'hF, 4'h2, 4'h0, 1'b0, 1'b0},
    {3'd6, 4'hF, 4'h2, 4'hF, 1'b0, 1'b0},
    {3'd7, 4'hF, 4'h2, 4'h2, 1'b0, 1'b0},
    {3'd0, 4'h9, 4'h7, 4'h0, 1'b1, 1'b0},
    {3'd1, 4'h9, 4'h7, 4'h2, 1'b1, 1'b1},
    {3'd2, 4'h9, 4'h7, 4'h8, 1'b0, 1'b1},
    {3'd3, 4'h9, 4'h7, 4'h6, 1'b1, 1'b0},
    {3'd4, 4'h9, 4'h7, 4'h7, 1'b0, 1'b0},
    {3'd5, 4'h9, 4'h7, 4'h6, 1'b0, 1'b0},
    {3'd6, 4'h9, 4'h7, 4'hF, 1'b0, 1'b0},
    {3'd7, 4'h9, 4'h7, 4'h1, 1'b0, 1'b0}
  };

  function automatic string tag(input int s);
    case (s)
      0: return "R1/R7";
      1: return "R2/R8";
      2, 3: return "R3/R9";
      4: return "R4/R10";
      default: return "R5/R6";
    endcase
  endfunction

  // reference: {r, carry, ovf} from integer arithmetic
  function automatic logic [W+1:0] model(input int s, input int ua, input int ub);
    int sa, sb, ur, sr;
    logic c;
    sa = (ua >= N/2) ? ua - N : ua;
    sb = (ub >= N/2) ? ub - N : ub;
    ur = 0; sr = 0; c = 1'b0;
    case (s)
      0: begin ur = ua + ub; sr = sa + sb; c = (ur >= N); end
      1: begin ur = ua - ub + N; sr = sa - sb; c = (ua >= ub); end
      2: begin ur = ub + 1; sr = sb + 1; c = (ub == N - 1); end
      3: begin ur = ub - 1 + N; sr = sb - 1; c = (ub != 0); end
      4: begin ur = N - ua; sr = -sa; c = (ua == 0); end
      5: ur = (~ua) & (N - 1);
      6: ur = ua | ub;
      default: ur = ua & ub;
    endcase
    return {W'(ur % N), c, (s <= 4) && (sr < -N/2 || sr > N/2 - 1)};
  endfunction

  task automatic apply_check(input int s, input int ua, input int ub,
                             input logic [W+1:0] exp, input string req);
    @(posedge clk);
    sel = 3'(s); a = W'(ua); b = W'(ub);
    @(negedge clk);
    checks++;
    if ({r, carry, ovf} !== exp) begin
      errors++;
      $display("FAIL %s sel=%0d a=%h b=%h got r=%h c=%b o=%b exp r=%h c=%b o=%b",
               req, s, ua, ub, r, carry, ovf, exp[W+1:2], exp[1], exp[0]);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // idle state: zero inputs add to zero, no flags (R1)
    apply_check(0, 0, 0, {4'h0, 1'b0, 1'b0}, "R1 idle");
    foreach (VEC[i])
      apply_check(int'(VEC[i][16:14]), int'(VEC[i][13:10]), int'(VEC[i][9:6]),
                  VEC[i][5:0], tag(int'(VEC[i][16:14])));
    for (int s = 0; s < 8; s++)
      for (int ia = 0; ia < N; ia++)
        for (int ib = 0; ib < N; ib++)
          apply_check(s, ia, ib, model(s, ia, ib), tag(s));
    // flag corner cases
    apply_check(2, 0, 7, {4'h8, 1'b0, 1'b1}, "R9 inc ovf");
    apply_check(2, 0, 15, {4'h0, 1'b1, 1'b0}, "R9 inc carry");
    apply_check(3, 0, 8, {4'h7, 1'b1, 1'b1}, "R9 dec ovf");
    apply_check(3, 0, 0, {4'hF, 1'b0, 1'b0}, "R9 dec borrow");
    apply_check(4, 0, 0, {4'h0, 1'b1, 1'b0}, "R10 neg zero");
    apply_check(4, 8, 0, {4'h8, 1'b0, 1'b1}, "R10 neg min");
    apply_check(0, 7, 1, {4'h8, 1'b0, 1'b1}, "R7 add pos ovf");
    apply_check(0, 8, 8, {4'h0, 1'b1, 1'b1}, "R7 add neg ovf");
    apply_check(1, 3, 5, {4'hE, 1'b0, 1'b0}, "R2 borrow");
    apply_check(1, 8, 1, {4'h7, 1'b1, 1'b1}, "R8 sub ovf");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule